// File: doc/BRIEF.md
# UART Interrupt Identification and FIFO Threshold Logic

This block is the interrupt and status decision logic of a 16550-style serial port. The block does not hold the FIFO storage, the serial shifters or the baud divider. It takes the receive and transmit FIFO occupancy counts, a line-error flag, a busy flag, a once-per-character-time tick and the FIFO push and pop strobes. From these inputs it produces a 4-bit interrupt identification code, one interrupt request line and three polled status flags.

Software writes three things into the block:
- the interrupt-enable bits;
- a 2-bit receive trigger select and a 2-bit transmit trigger select;
- a soft-reset word.

The soft-reset word can return the block's configuration to its reset values. It can also request a flush of either FIFO. Each flush request comes out as a one-cycle strobe to the FIFO logic.

When more than one source is pending, the block reports only the source with the highest priority. The identification code is combinational from the registered configuration and the live inputs. Reading the code while it shows transmit-empty acknowledges that source.

Top module: `uart_irq_ctrl`

## Requirements
- R1: Status flags follow the counts: `rx_not_empty` is high when `rx_count` is nonzero, `tx_not_full` is high when `tx_count` is below FIFO_DEPTH, and `tx_empty` is high when `tx_count` is zero.
- R2: Codes are 1 none, 2 transmit empty, 4 receive data, 5 line status, 7 busy, 12 character timeout. Priority from highest to lowest is line status, receive data, timeout, transmit empty, busy. Line status and busy are never masked.
- R3: With enable bit 0 set, code 4 is reported while `rx_count` is at or above the selected receive level. The receive select values are 0 for one character, 1 for FIFO_DEPTH/4, 2 for FIFO_DEPTH/2 and 3 for FIFO_DEPTH-2.
- R4: With enable bit 0 set and `rx_count` nonzero, code 12 is reported once TO_CHARS `char_tick` pulses have passed with no `rx_push` and no `rx_pop`. A push or a pop restarts the count.
- R5: With enable bit 1 set and enable bit 7 clear, code 2 is reported when `tx_count` is zero.
- R6: With enable bits 1 and 7 set, code 2 is reported while `tx_count` is at or below the selected transmit level. The transmit select values are 0 for empty, 1 for two characters, 2 for FIFO_DEPTH/4 and 3 for FIFO_DEPTH/2.
- R7: An `id_rd` while the code is 2 suppresses the transmit source from the next cycle onward. The suppression ends with the next `tx_push`.
- R8: Code 7 is reported only when `busy` is high and no other source is pending. `irq` is high exactly when the code differs from 1.
- R9: A soft-reset write produces a one-cycle strobe on the following cycle. Bit 1 of the word requests `rx_flush`, bit 2 requests `tx_flush`, and bit 0 requests both strobes and also returns the enables, the trigger selects and the transmit acknowledge to their reset values.
- R10: After reset the code is 1, `irq` is low, both flush strobes are low, and all enables and trigger selects are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ien_wr | input | 1 | Write strobe for the interrupt-enable register |
| ien_wdata | input | 8 | Enable value: bit 0 receive, bit 1 transmit, bit 7 transmit threshold mode |
| trig_wr | input | 1 | Write strobe for both trigger selects |
| rx_trig_wdata | input | 2 | Receive trigger select |
| tx_trig_wdata | input | 2 | Transmit trigger select |
| srst_wr | input | 1 | Soft-reset write strobe |
| srst_wdata | input | 3 | Soft-reset word: bit 0 full reset, bit 1 receive flush, bit 2 transmit flush |
| rx_count | input | $clog2(FIFO_DEPTH+1) | Receive FIFO occupancy |
| tx_count | input | $clog2(FIFO_DEPTH+1) | Transmit FIFO occupancy |
| rx_push | input | 1 | A character entered the receive FIFO |
| rx_pop | input | 1 | A character was read from the receive FIFO |
| tx_push | input | 1 | A character was written to the transmit FIFO |
| char_tick | input | 1 | One pulse per character time |
| line_err | input | 1 | A line error is pending |
| busy | input | 1 | Busy condition is pending |
| id_rd | input | 1 | Software reads the identification code |
| int_id | output | 4 | Interrupt identification code |
| irq | output | 1 | Interrupt request |
| rx_not_empty | output | 1 | Receive FIFO holds data |
| tx_not_full | output | 1 | Transmit FIFO has room |
| tx_empty | output | 1 | Transmit FIFO is empty |
| rx_flush | output | 1 | Receive FIFO flush strobe |
| tx_flush | output | 1 | Transmit FIFO flush strobe |

## Verification
Each trigger select is tested with occupancy one below its level and at its level, so an off-by-one compare or a swapped decode changes the reported code. Sources are stacked in pairs (line error with receive data, receive data with timeout, busy with transmit empty) to show the priority order apart from the individual conditions. The timeout is driven with one tick fewer than needed and then with the full count, followed by a pop, which separates the saturation point from the restart. The acknowledge sequence of read, then silence, then push, together with single-bit soft-reset words, shows that each strobe and each clear has its own effect.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
   typedef enum logic [3:0] {
      IID_NONE   = 4'd1,
      IID_THRE   = 4'd2,
      IID_RXDATA = 4'd4,
      IID_LINE   = 4'd5,
      IID_BUSY   = 4'd7,
      IID_TMO    = 4'd12
   } iid_e;

   localparam int IEN_RX   = 0;
   localparam int IEN_TX   = 1;
   localparam int IEN_PROG = 7;

   localparam int SRST_UART = 0;
   localparam int SRST_RXF  = 1;
   localparam int SRST_TXF  = 2;
endpackage

// File: rtl/uart_irq_levels.sv
module uart_irq_levels #(
   parameter int FIFO_DEPTH = 16,
   parameter int CW         = $clog2(FIFO_DEPTH + 1)
) (
   input  logic [1:0]    rx_sel,
   input  logic [1:0]    tx_sel,
   output logic [CW-1:0] rx_lvl,
   output logic [CW-1:0] tx_lvl
);
   localparam logic [CW-1:0] L_ONE  = CW'(1);
   localparam logic [CW-1:0] L_TWO  = CW'(2);
   localparam logic [CW-1:0] L_QTR  = CW'(FIFO_DEPTH / 4);
   localparam logic [CW-1:0] L_HALF = CW'(FIFO_DEPTH / 2);
   localparam logic [CW-1:0] L_NEAR = CW'(FIFO_DEPTH - 2);

   generate
      if (FIFO_DEPTH < 8 || (FIFO_DEPTH & (FIFO_DEPTH - 1)) != 0) begin : g_bad_depth
         $error("FIFO_DEPTH must be a power of two of at least 8");
      end
   endgenerate

   always_comb begin
      unique case (rx_sel)
         2'd0:    rx_lvl = L_ONE;
         2'd1:    rx_lvl = L_QTR;
         2'd2:    rx_lvl = L_HALF;
         default: rx_lvl = L_NEAR;
      endcase
      unique case (tx_sel)
         2'd0:    tx_lvl = '0;
         2'd1:    tx_lvl = L_TWO;
         2'd2:    tx_lvl = L_QTR;
         default: tx_lvl = L_HALF;
      endcase
   end
endmodule

// File: rtl/uart_irq_tmo.sv
module uart_irq_tmo #(
   parameter int CW       = 5,
   parameter int TO_CHARS = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic [CW-1:0] rx_count,
   input  logic          rx_push,
   input  logic          rx_pop,
   input  logic          char_tick,
   output logic          tmo
);
   localparam int TW = $clog2(TO_CHARS + 1);
   localparam logic [TW-1:0] T_MAX = TW'(TO_CHARS);

   logic [TW-1:0] cnt_q;
   logic          idle_clr;

   generate
      if (TO_CHARS < 1) begin : g_bad_to
         $error("TO_CHARS must be at least 1");
      end
   endgenerate

   assign idle_clr = clr | rx_push | rx_pop | (rx_count == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        cnt_q <= '0;
      else if (idle_clr)                 cnt_q <= '0;
      else if (char_tick && cnt_q != T_MAX) cnt_q <= cnt_q + 1'b1;
   end

   assign tmo = (cnt_q == T_MAX) && (rx_count != '0);

   // R4
   tmo_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= T_MAX);
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
   import uart_irq_pkg::*;
(
   input  logic src_line,
   input  logic src_rx,
   input  logic src_tmo,
   input  logic src_tx,
   input  logic src_busy,
   output iid_e id
);
   always_comb begin
      if (src_line)      id = IID_LINE;
      else if (src_rx)   id = IID_RXDATA;
      else if (src_tmo)  id = IID_TMO;
      else if (src_tx)   id = IID_THRE;
      else if (src_busy) id = IID_BUSY;
      else               id = IID_NONE;
   end
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
   import uart_irq_pkg::*;
#(
   parameter int FIFO_DEPTH = 16,
   parameter int TO_CHARS   = 4,
   localparam int CW        = $clog2(FIFO_DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ien_wr,
   input  logic [7:0]    ien_wdata,
   input  logic          trig_wr,
   input  logic [1:0]    rx_trig_wdata,
   input  logic [1:0]    tx_trig_wdata,
   input  logic          srst_wr,
   input  logic [2:0]    srst_wdata,
   input  logic [CW-1:0] rx_count,
   input  logic [CW-1:0] tx_count,
   input  logic          rx_push,
   input  logic          rx_pop,
   input  logic          tx_push,
   input  logic          char_tick,
   input  logic          line_err,
   input  logic          busy,
   input  logic          id_rd,
   output logic [3:0]    int_id,
   output logic          irq,
   output logic          rx_not_empty,
   output logic          tx_not_full,
   output logic          tx_empty,
   output logic          rx_flush,
   output logic          tx_flush
);
   localparam logic [CW-1:0] FULL = CW'(FIFO_DEPTH);

   logic          en_rx_q, en_tx_q, en_prog_q;
   logic [1:0]    rx_sel_q, tx_sel_q;
   logic          tx_ack_q;
   logic          soft_rst;
   logic [CW-1:0] rx_lvl, tx_lvl;
   logic          tmo, tx_cond;
   logic          src_rx, src_tmo, src_tx;
   iid_e          id;
   logic          unused_ien;

   assign unused_ien = ^ien_wdata[6:2];
   assign soft_rst   = srst_wr & srst_wdata[SRST_UART];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_rx_q <= 1'b0; en_tx_q <= 1'b0; en_prog_q <= 1'b0;
         rx_sel_q <= 2'd0; tx_sel_q <= 2'd0;
      end else if (soft_rst) begin
         en_rx_q <= 1'b0; en_tx_q <= 1'b0; en_prog_q <= 1'b0;
         rx_sel_q <= 2'd0; tx_sel_q <= 2'd0;
      end else begin
         if (ien_wr) begin
            en_rx_q   <= ien_wdata[IEN_RX];
            en_tx_q   <= ien_wdata[IEN_TX];
            en_prog_q <= ien_wdata[IEN_PROG];
         end
         if (trig_wr) begin
            rx_sel_q <= rx_trig_wdata;
            tx_sel_q <= tx_trig_wdata;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                            tx_ack_q <= 1'b0;
      else if (soft_rst || tx_push)          tx_ack_q <= 1'b0;
      else if (id_rd && id == IID_THRE)      tx_ack_q <= 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_flush <= 1'b0;
         tx_flush <= 1'b0;
      end else begin
         rx_flush <= srst_wr & (srst_wdata[SRST_RXF] | srst_wdata[SRST_UART]);
         tx_flush <= srst_wr & (srst_wdata[SRST_TXF] | srst_wdata[SRST_UART]);
      end
   end

   uart_irq_levels #(.FIFO_DEPTH(FIFO_DEPTH), .CW(CW)) u_lvl (
      .rx_sel(rx_sel_q), .tx_sel(tx_sel_q), .rx_lvl(rx_lvl), .tx_lvl(tx_lvl)
   );

   uart_irq_tmo #(.CW(CW), .TO_CHARS(TO_CHARS)) u_tmo (
      .clk(clk), .rst_n(rst_n), .clr(soft_rst), .rx_count(rx_count),
      .rx_push(rx_push), .rx_pop(rx_pop), .char_tick(char_tick), .tmo(tmo)
   );

   assign tx_cond = en_prog_q ? (tx_count <= tx_lvl) : (tx_count == '0);
   assign src_rx  = en_rx_q & (rx_count >= rx_lvl);
   assign src_tmo = en_rx_q & tmo;
   assign src_tx  = en_tx_q & ~tx_ack_q & tx_cond;

   uart_irq_prio u_prio (
      .src_line(line_err), .src_rx(src_rx), .src_tmo(src_tmo),
      .src_tx(src_tx), .src_busy(busy), .id(id)
   );

   assign int_id       = id;
   assign irq          = (id != IID_NONE);
   assign rx_not_empty = (rx_count != '0);
   assign tx_not_full  = (tx_count < FULL);
   assign tx_empty     = (tx_count == '0);

   // R2
   line_pri_chk: assert property (@(posedge clk) disable iff (!rst_n)
      line_err |-> int_id == IID_LINE);
   // R7
   tx_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (id_rd && int_id == IID_THRE && !tx_push) |=> int_id != IID_THRE);
   // R9
   rx_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (srst_wr && (srst_wdata[SRST_RXF] || srst_wdata[SRST_UART])) |=> rx_flush);
   // R9
   tx_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (srst_wr && (srst_wdata[SRST_TXF] || srst_wdata[SRST_UART])) |=> tx_flush);
   // R4
   tmo_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      int_id == IID_TMO |-> rx_count != '0);
   // R8
   busy_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      int_id == IID_BUSY |-> busy);
endmodule

// File: tb/sim_uart_irq_ctrl.sv
module sim_uart_irq_ctrl;
   localparam int CLK_PERIOD = 10;
   localparam int DEPTH = 16;
   localparam int CW = $clog2(DEPTH + 1);

   logic clk = 1'b0, rst_n = 1'b0;
   logic ien_wr = 0, trig_wr = 0, srst_wr = 0;
   logic [7:0] ien_wdata = 0;
   logic [1:0] rx_trig_wdata = 0, tx_trig_wdata = 0;
   logic [2:0] srst_wdata = 0;
   logic [CW-1:0] rx_count = 0, tx_count = 0;
   logic rx_push = 0, rx_pop = 0, tx_push = 0, char_tick = 0;
   logic line_err = 0, busy = 0, id_rd = 0;
   logic [3:0] int_id;
   logic irq, rx_not_empty, tx_not_full, tx_empty, rx_flush, tx_flush;

   int n_chk = 0, n_fail = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   uart_irq_ctrl #(.FIFO_DEPTH(DEPTH), .TO_CHARS(4)) u0 (.*);

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // advance one edge; inputs then change 1 time unit after it
   task automatic step();
      @(posedge clk); #1;
   endtask

   task automatic set_ien(input logic [7:0] v);
      ien_wdata = v; ien_wr = 1; step(); ien_wr = 0;
   endtask

   task automatic set_trig(input logic [1:0] r, input logic [1:0] t);
      rx_trig_wdata = r; tx_trig_wdata = t; trig_wr = 1; step(); trig_wr = 0;
   endtask

   task automatic id_at(input string req, input int rc, input int tc, input int exp);
      rx_count = CW'(rc); tx_count = CW'(tc); #1;
      chk(req, int_id, exp);
   endtask

   task automatic t_reset();
      #1;
      chk("R10 id", int_id, 1);
      chk("R10 irq", irq, 0);
      chk("R10 rx_flush", rx_flush, 0);
      chk("R10 tx_flush", tx_flush, 0);
      chk("R1 rx_not_empty", rx_not_empty, 0);
      chk("R1 tx_not_full", tx_not_full, 1);
      chk("R1 tx_empty", tx_empty, 1);
      // R10: enables zero, so full rx with low occupancy tx still reports none
      id_at("R10 enables off", 16, 0, 1);
   endtask

   task automatic t_status();
      rx_count = 3; tx_count = 16; #1;
      chk("R1 rx_not_empty", rx_not_empty, 1);
      chk("R1 tx_not_full full", tx_not_full, 0);
      chk("R1 tx_empty", tx_empty, 0);
      tx_count = 15; #1;
      chk("R1 tx_not_full 15", tx_not_full, 1);
      rx_count = 0; tx_count = 0;
   endtask

   task automatic t_rx_levels();
      set_ien(8'h01);
      set_trig(2'd0, 2'd0);
      id_at("R3 sel0 below", 0, 5, 1);
      id_at("R3 sel0 at", 1, 5, 4);
      chk("R8 irq with rx", irq, 1);
      set_trig(2'd1, 2'd0);
      id_at("R3 sel1 below", 3, 5, 1);
      id_at("R3 sel1 at", 4, 5, 4);
      set_trig(2'd2, 2'd0);
      id_at("R3 sel2 below", 7, 5, 1);
      id_at("R3 sel2 at", 8, 5, 4);
      set_trig(2'd3, 2'd0);
      id_at("R3 sel3 below", 13, 5, 1);
      id_at("R3 sel3 at", 14, 5, 4);
      rx_count = 0; step();
   endtask

   task automatic t_priority();
      set_ien(8'h03);
      set_trig(2'd0, 2'd0);
      line_err = 1;
      id_at("R2 line over rx", 2, 5, 5);
      line_err = 0;
      id_at("R2 rx over tx", 2, 0, 4);
      busy = 1;
      id_at("R8 tx over busy", 0, 0, 2);
      set_ien(8'h00);
      id_at("R8 busy alone", 0, 0, 7);
      chk("R8 irq busy", irq, 1);
      busy = 0; #1;
      chk("R8 id none", int_id, 1);
      chk("R8 irq low", irq, 0);
   endtask

   task automatic t_timeout();
      set_ien(8'h01);
      set_trig(2'd3, 2'd0);
      rx_count = 2; tx_count = 5; step();
      for (int i = 0; i < 3; i++) begin char_tick = 1; step(); char_tick = 0; step(); end
      #1; chk("R4 three ticks", int_id, 1);
      char_tick = 1; step(); char_tick = 0; #1;
      chk("R4 four ticks", int_id, 12);
      rx_count = 14; #1;
      chk("R2 rx over timeout", int_id, 4);
      rx_count = 2; #1;
      rx_pop = 1; step(); rx_pop = 0; #1;
      chk("R4 pop restarts", int_id, 1);
      for (int i = 0; i < 4; i++) begin char_tick = 1; step(); end
      char_tick = 0; #1;
      chk("R4 again", int_id, 12);
      rx_push = 1; step(); rx_push = 0; #1;
      chk("R4 push restarts", int_id, 1);
      rx_count = 0; step();
   endtask

   task automatic t_tx_normal();
      set_ien(8'h02);
      id_at("R5 one left", 0, 1, 1);
      id_at("R5 empty", 0, 0, 2);
   endtask

   task automatic t_tx_prog();
      set_ien(8'h82);
      set_trig(2'd0, 2'd1);
      id_at("R6 sel1 above", 0, 3, 1);
      id_at("R6 sel1 at", 0, 2, 2);
      set_trig(2'd0, 2'd2);
      id_at("R6 sel2 at", 0, 4, 2);
      id_at("R6 sel2 above", 0, 5, 1);
      set_trig(2'd0, 2'd3);
      id_at("R6 sel3 at", 0, 8, 2);
      id_at("R6 sel3 above", 0, 9, 1);
      set_trig(2'd0, 2'd0);
      id_at("R6 sel0 at", 0, 0, 2);
      id_at("R6 sel0 above", 0, 1, 1);
   endtask

   task automatic t_tx_ack();
      set_ien(8'h02);
      id_at("R7 before read", 0, 0, 2);
      id_rd = 1; step(); id_rd = 0; #1;
      chk("R7 after read", int_id, 1);
      step(); #1;
      chk("R7 still cleared", int_id, 1);
      tx_push = 1; step(); tx_push = 0; #1;
      chk("R7 after push", int_id, 2);
   endtask

   task automatic t_srst();
      srst_wdata = 3'b010; srst_wr = 1; step(); srst_wr = 0; #1;
      chk("R9 rx flush", rx_flush, 1);
      chk("R9 no tx flush", tx_flush, 0);
      chk("R9 config kept", int_id, 2);
      step(); #1;
      chk("R9 rx flush one cycle", rx_flush, 0);
      srst_wdata = 3'b100; srst_wr = 1; step(); srst_wr = 0; #1;
      chk("R9 tx flush", tx_flush, 1);
      chk("R9 no rx flush", rx_flush, 0);
      step();
      set_ien(8'h01);
      set_trig(2'd3, 2'd0);
      srst_wdata = 3'b001; srst_wr = 1; step(); srst_wr = 0; #1;
      chk("R9 both flush rx", rx_flush, 1);
      chk("R9 both flush tx", tx_flush, 1);
      set_ien(8'h01);
      // selects back at 0: one character now triggers receive data
      id_at("R9 selects reset", 1, 5, 4);
      set_ien(8'h02);
      srst_wdata = 3'b001; srst_wr = 1; step(); srst_wr = 0;
      id_at("R9 enables reset", 0, 0, 1);
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      step();
      t_reset();
      t_status();
      t_rx_levels();
      t_priority();
      t_timeout();
      t_tx_normal();
      t_tx_prog();
      t_tx_ack();
      t_srst();
      step();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule